// File: doc/BRIEF.md
# Scatter-Gather DMA Channel

This block is one DMA channel that copies 32-bit words between two address spaces, called host space and local space. Software sets it up through six word-wide registers: two start addresses, a byte count, a descriptor pointer, a mode word and a command/status word. One write to the command register then starts the channel.

With chaining off, the channel makes one transfer using the address and count registers as software wrote them. With chaining on, it walks a linked list of 16-byte descriptors held in either address space. Each descriptor is fetched into the channel registers and carried out before the channel follows the pointer to the next one.

Every memory access goes through a single request/acknowledge port that carries a space select bit. Each data word is one read from the source followed by one write to the destination. A level interrupt output can be raised when the whole run ends, when a marked descriptor ends, or both.

Top module: `sg_dma_chan`

## Requirements
- R1: After reset, all registers read 0 except status, which reads 0x10 (done set, enable clear). The interrupt output is low and no memory request is made.
- R2: The register select codes are 0 host address, 1 local address, 2 byte count, 3 descriptor pointer, 4 mode and 5 command/status. Only the low 23 bits of the count are stored; the upper bits read as 0.
- R3: A write to select 5 with both bit 0 (enable) and bit 1 (start) set starts an idle channel. A write with bit 1 set and bit 0 clear starts nothing. Status bit 0 reads back the enable. Status bit 4 (done) reads 0 from the cycle after the start until the run ends, and reads 1 afterwards.
- R4: With mode bit 9 clear, the channel moves ceil(count/4) words. For each word it reads the source and then writes the destination. Bit 3 of the pointer register picks the direction: 1 is local to host, 0 is host to local. Both addresses step by 4 per word, and at the end the count reads 0.
- R5: With mode bit 11 set, the local address does not change during a transfer.
- R6: A run with a count of 0 sets done and makes no memory access.
- R7: With mode bit 9 set, the channel reads the four descriptor words in this order: host address, local address, count, next pointer. It reads them from address pointer[31:4]*16, in host space when pointer bit 0 is 1. The flags of the loaded pointer then control that descriptor: bit 3 sets its direction, bit 2 asks for an interrupt when it ends, bit 1 marks it as the last one, and bit 0 gives the space of the next descriptor.
- R8: With mode bits 9 and 16 both set, the channel writes 0 to each descriptor's count word (offset 8) after that descriptor's data. With bit 16 clear, the descriptor in memory is left unchanged.
- R9: The interrupt is set when a run ends if mode bit 10 is set, and when a descriptor that has flag bit 2 ends. Writing 1 to command bit 3 clears it. If a set and a clear fall in the same cycle, the set wins.
- R10: Writing command bit 2 during a run stops it at the next word boundary. No memory access follows. Done is set, and the address and count registers keep the values they reached.
- R11: Once a memory request is raised, it stays up with the same address and the same write select until it is acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 3 | Register select |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational from reg_sel) |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_host | output | 1 | 1 = host space, 0 = local space |
| mem_addr | output | 32 | Byte address of the word |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid with mem_ack |
| mem_ack | input | 1 | Access completes in this cycle |
| irq | output | 1 | Channel interrupt |

## Verification
A wrong flag or count inside the channel shows at the ports within a few cycles. The channel may make one write too many or too few to the destination, or it may leave the count register non-zero after done. A descriptor loaded from the wrong word shows up as a destination address outside the expected window. A missed end-of-chain flag shows up as an extra fetch that is visible on the memory port. A stuck state or a lost abort keeps the done bit low, and the first status poll after the expected finish catches it.

// File: rtl/sg_dma_chan.sv
module sg_dma_chan #(
  parameter int CNT_W = 23
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic [2:0]  reg_sel,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        mem_req,
  output logic        mem_we,
  output logic        mem_host,
  output logic [31:0] mem_addr,
  output logic [31:0] mem_wdata,
  input  logic [31:0] mem_rdata,
  input  logic        mem_ack,
  output logic        irq
);

  typedef enum logic [2:0] {S_IDLE, S_FETCH, S_STEP, S_RD, S_WR, S_WB} state_t;

  state_t           st;
  logic [31:0]      host_a, loc_a, nxt, mode_q, buf_q;
  logic [CNT_W-1:0] cnt;
  logic [27:0]      dbase;
  logic             dhost, en_q, abort_p, irq_q, wb_done;
  logic [1:0]       fidx;

  logic busy, cmd_wr, start, l2h, last_w, chain;

  assign busy   = (st != S_IDLE);
  assign cmd_wr = reg_wr && (reg_sel == 3'd5);
  assign start  = cmd_wr && reg_wdata[0] && reg_wdata[1] && !busy;
  assign l2h    = nxt[3];
  assign chain  = mode_q[9];
  assign last_w = (cnt <= CNT_W'(4));
  assign irq    = irq_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      host_a  <= '0;
      loc_a   <= '0;
      cnt     <= '0;
      nxt     <= '0;
      mode_q  <= '0;
      buf_q   <= '0;
      dbase   <= '0;
      dhost   <= 1'b0;
      en_q    <= 1'b0;
      abort_p <= 1'b0;
      irq_q   <= 1'b0;
      wb_done <= 1'b0;
      fidx    <= '0;
    end else begin
      if (reg_wr && !busy) begin
        case (reg_sel)
          3'd0: host_a <= reg_wdata;
          3'd1: loc_a  <= reg_wdata;
          3'd2: cnt    <= reg_wdata[CNT_W-1:0];
          3'd3: nxt    <= reg_wdata;
          3'd4: mode_q <= reg_wdata;
          default: ;
        endcase
      end
      if (cmd_wr) begin
        en_q <= reg_wdata[0];
        if (reg_wdata[3]) irq_q <= 1'b0;
        if (reg_wdata[2] && busy) abort_p <= 1'b1;
      end

      case (st)
        S_IDLE: begin
          if (start) begin
            abort_p <= 1'b0;
            wb_done <= 1'b0;
            if (chain) begin
              st    <= S_FETCH;
              fidx  <= '0;
              dbase <= nxt[31:4];
              dhost <= nxt[0];
            end else begin
              st <= S_STEP;
            end
          end
        end
        S_FETCH: begin
          if (mem_ack) begin
            case (fidx)
              2'd0: host_a <= mem_rdata;
              2'd1: loc_a  <= mem_rdata;
              2'd2: cnt    <= mem_rdata[CNT_W-1:0];
              default: begin
                nxt <= mem_rdata;
                st  <= S_STEP;
              end
            endcase
            fidx <= fidx + 2'd1;
          end
        end
        S_STEP: begin
          if (abort_p) begin
            st      <= S_IDLE;
            abort_p <= 1'b0;
            if (mode_q[10]) irq_q <= 1'b1;
          end else if (cnt != '0) begin
            st <= S_RD;
          end else if (chain && mode_q[16] && !wb_done) begin
            st <= S_WB;
          end else begin
            if (chain && nxt[2]) irq_q <= 1'b1;
            wb_done <= 1'b0;
            if (chain && !nxt[1]) begin
              st    <= S_FETCH;
              fidx  <= '0;
              dbase <= nxt[31:4];
              dhost <= nxt[0];
            end else begin
              st <= S_IDLE;
              if (mode_q[10]) irq_q <= 1'b1;
            end
          end
        end
        S_RD: begin
          if (mem_ack) begin
            buf_q <= mem_rdata;
            st    <= S_WR;
          end
        end
        S_WR: begin
          if (mem_ack) begin
            host_a <= host_a + 32'd4;
            if (!mode_q[11]) loc_a <= loc_a + 32'd4;
            cnt <= last_w ? '0 : cnt - CNT_W'(4);
            st  <= S_STEP;
          end
        end
        S_WB: begin
          if (mem_ack) begin
            wb_done <= 1'b1;
            st      <= S_STEP;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_host  = 1'b0;
    mem_addr  = '0;
    mem_wdata = '0;
    case (st)
      S_FETCH: begin
        mem_req  = 1'b1;
        mem_host = dhost;
        mem_addr = {dbase, fidx, 2'b00};
      end
      S_RD: begin
        mem_req  = 1'b1;
        mem_host = !l2h;
        mem_addr = l2h ? loc_a : host_a;
      end
      S_WR: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_host  = l2h;
        mem_addr  = l2h ? host_a : loc_a;
        mem_wdata = buf_q;
      end
      S_WB: begin
        mem_req  = 1'b1;
        mem_we   = 1'b1;
        mem_host = dhost;
        mem_addr = {dbase, 4'h8};
      end
      default: ;
    endcase
  end

  always_comb begin
    case (reg_sel)
      3'd0:    reg_rdata = host_a;
      3'd1:    reg_rdata = loc_a;
      3'd2:    reg_rdata = {{(32-CNT_W){1'b0}}, cnt};
      3'd3:    reg_rdata = nxt;
      3'd4:    reg_rdata = mode_q;
      3'd5:    reg_rdata = {27'd0, !busy, 3'd0, en_q};
      default: reg_rdata = '0;
    endcase
  end

endmodule

// File: rtl/sg_dma_chan_chk.sv
module sg_dma_chan_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        reg_wr,
  input logic [2:0]  reg_sel,
  input logic [31:0] reg_wdata,
  input logic        mem_req,
  input logic        mem_we,
  input logic [31:0] mem_addr,
  input logic        mem_ack,
  input logic        irq,
  input logic        busy,
  input logic [31:0] mode_q
);

  AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_sel == 3'd5 && reg_wdata[1:0] == 2'b11 && !busy) |=> busy); // R3

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_req); // R10

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we))); // R11

  AST_DONE_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(busy) && mode_q[10]) |-> irq); // R9

  AST_IRQ_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_sel == 3'd5 && reg_wdata[3] && !reg_wdata[1] && !busy) |=> !irq); // R9

endmodule

bind sg_dma_chan sg_dma_chan_chk i_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
  .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_ack(mem_ack),
  .irq(irq), .busy(busy), .mode_q(mode_q)
);

// File: tb/test_sg_dma_chan.sv
`timescale 1ns/1ps
module test_sg_dma_chan;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [2:0]  reg_sel = 3'd0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        mem_req, mem_we, mem_host, mem_ack;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic        irq;

  logic [31:0] host_mem [64];
  logic [31:0] loc_mem  [64];
  logic        stall = 1'b0;
  logic        tgl = 1'b0;
  int          acc = 0;
  int          wrs = 0;
  logic        pk_h = 1'b0, pk_l = 1'b0;
  logic [5:0]  pk_idx = '0;
  logic [31:0] pk_hd = '0, pk_ld = '0;

  int total = 0;
  int bad = 0;

  always #2.5 clk = ~clk;

  sg_dma_chan i_sg_dma_chan (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .mem_req(mem_req), .mem_we(mem_we), .mem_host(mem_host),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack),
    .irq(irq)
  );

  assign mem_ack   = mem_req && (!stall || tgl);
  assign mem_rdata = mem_host ? host_mem[mem_addr[7:2]] : loc_mem[mem_addr[7:2]];

  always @(posedge clk) begin
    tgl <= ~tgl;
    if (pk_h) host_mem[pk_idx] <= pk_hd;
    if (pk_l) loc_mem[pk_idx]  <= pk_ld;
    if (mem_req && mem_ack) begin
      acc <= acc + 1;
      if (mem_we) begin
        wrs <= wrs + 1;
        if (mem_host) host_mem[mem_addr[7:2]] <= mem_wdata;
        else          loc_mem[mem_addr[7:2]]  <= mem_wdata;
      end
    end
  end

  // bits: [33] dir local->host, [32] local constant, [31:24] host addr, [23:16] local addr, [15:0] size
  localparam logic [33:0] VEC [4] = '{
    {1'b0, 1'b0, 8'h10, 8'h40, 16'd16},
    {1'b1, 1'b0, 8'h80, 8'h20, 16'd12},
    {1'b0, 1'b1, 8'h20, 8'h60, 16'd8},
    {1'b1, 1'b0, 8'h00, 8'h90, 16'd6}
  };

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wreg(input logic [2:0] s, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_sel = s; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rreg(input logic [2:0] s, output logic [31:0] d);
    @(negedge clk);
    reg_sel = s;
    #1 d = reg_rdata;
  endtask

  task automatic poke(input bit h, input bit l, input int idx, input logic [31:0] hd, input logic [31:0] ld);
    @(negedge clk);
    pk_h = h; pk_l = l; pk_idx = idx[5:0]; pk_hd = hd; pk_ld = ld;
    @(negedge clk);
    pk_h = 1'b0; pk_l = 1'b0;
  endtask

  function automatic logic [31:0] hpat(int s, int i);
    return 32'hA000_0000 + s * 256 + i;
  endfunction
  function automatic logic [31:0] lpat(int s, int i);
    return 32'h5000_0000 + s * 256 + i;
  endfunction

  task automatic fill(input int s);
    for (int i = 0; i < 64; i++) poke(1'b1, 1'b1, i, hpat(s, i), lpat(s, i));
  endtask

  task automatic wait_done(input string req);
    logic [31:0] d;
    for (int i = 0; i < 3000; i++) begin
      rreg(3'd5, d);
      if (d[4]) return;
    end
    chk(1'b0, req, d, 32'h10);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] d;
    int a0, w0, n, h, l, sz;
    bit dir, lc;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    for (int s = 0; s < 5; s++) begin
      rreg(s[2:0], d);
      chk(d == 32'd0, "R1 register zero", d, 32'd0);
    end
    rreg(3'd5, d);
    chk(d == 32'h10, "R1 status", d, 32'h10);
    chk(irq == 1'b0, "R1 irq", {31'd0, irq}, 32'd0);
    chk(acc == 0, "R1 no access", acc, 32'd0);

    // R2 register map and count width
    wreg(3'd2, 32'hFFFF_FFFF);
    rreg(3'd2, d);
    chk(d == 32'h007F_FFFF, "R2 count width", d, 32'h007F_FFFF);
    wreg(3'd0, 32'h1234_5678);
    rreg(3'd0, d);
    chk(d == 32'h1234_5678, "R2 host reg", d, 32'h1234_5678);

    // R3 start without enable does nothing
    a0 = acc;
    wreg(3'd5, 32'h2);
    repeat (5) @(negedge clk);
    rreg(3'd5, d);
    chk(d == 32'h10, "R3 no start without enable", d, 32'h10);
    chk(acc == a0, "R3 no access without enable", acc, a0);

    // R4 R5 R11 direct transfers from the vector table
    foreach (VEC[k]) begin
      dir = VEC[k][33]; lc = VEC[k][32];
      h = VEC[k][31:24]; l = VEC[k][23:16]; sz = VEC[k][15:0];
      n = (sz + 3) / 4;
      fill(k);
      stall = k[0];
      wreg(3'd0, h); wreg(3'd1, l); wreg(3'd2, sz);
      wreg(3'd3, {28'd0, dir, 3'd0}); wreg(3'd4, {20'd0, lc, 11'd0});
      w0 = wrs;
      wreg(3'd5, 32'h3);
      rreg(3'd5, d);
      chk(d == 32'h1, "R3 busy status", d, 32'h1);
      wait_done("R3 done after run");
      for (int j = 0; j < n; j++) begin
        if (!dir && !lc)
          chk(loc_mem[l/4 + j] == hpat(k, h/4 + j), "R4 host to local data", loc_mem[l/4 + j], hpat(k, h/4 + j));
        if (dir)
          chk(host_mem[h/4 + j] == lpat(k, l/4 + j), "R4 R11 local to host data", host_mem[h/4 + j], lpat(k, l/4 + j));
      end
      if (lc)
        chk(loc_mem[l/4] == hpat(k, h/4 + n - 1), "R5 constant local data", loc_mem[l/4], hpat(k, h/4 + n - 1));
      chk(wrs - w0 == n, "R4 word count", wrs - w0, n);
      rreg(3'd0, d);
      chk(d == h + 4 * n, "R4 host address end", d, h + 4 * n);
      rreg(3'd1, d);
      chk(d == (lc ? l : l + 4 * n), "R5 local address end", d, lc ? l : l + 4 * n);
      rreg(3'd2, d);
      chk(d == 32'd0, "R4 count end", d, 32'd0);
    end
    stall = 1'b0;

    // R6 zero size
    wreg(3'd2, 32'd0); wreg(3'd4, 32'd0);
    a0 = acc;
    wreg(3'd5, 32'h3);
    wait_done("R6 zero size done");
    repeat (3) @(negedge clk);
    rreg(3'd5, d);
    chk(d == 32'h11, "R6 zero size status", d, 32'h11);
    chk(acc == a0, "R6 no access", acc, a0);

    // R7 R8 R9 chain with clear-count
    for (int pass = 0; pass < 2; pass++) begin
      fill(9);
      poke(1'b1, 1'b0, 48, 32'h00, 0); poke(1'b1, 1'b0, 49, 32'h00, 0);
      poke(1'b1, 1'b0, 50, 32'd8, 0);  poke(1'b1, 1'b0, 51, 32'hD5, 0);
      poke(1'b1, 1'b0, 52, 32'h40, 0); poke(1'b1, 1'b0, 53, 32'h40, 0);
      poke(1'b1, 1'b0, 54, 32'd4, 0);  poke(1'b1, 1'b0, 55, 32'h0A, 0);
      wreg(3'd5, 32'h8);
      wreg(3'd3, 32'hC1);
      wreg(3'd4, pass == 0 ? 32'h0001_0200 : 32'h0000_0200);
      wreg(3'd5, 32'h3);
      wait_done("R7 chain done");
      chk(loc_mem[0] == hpat(9, 48 - 48), "R7 first block word 0", loc_mem[0], hpat(9, 0));
      chk(loc_mem[1] == hpat(9, 1), "R7 first block word 1", loc_mem[1], hpat(9, 1));
      chk(host_mem[16] == lpat(9, 16), "R7 second block local to host", host_mem[16], lpat(9, 16));
      rreg(3'd3, d);
      chk(d == 32'h0A, "R7 last pointer loaded", d, 32'h0A);
      rreg(3'd0, d);
      chk(d == 32'h44, "R7 host address end", d, 32'h44);
      chk(irq == 1'b1, "R9 terminal count irq", {31'd0, irq}, 32'd1);
      if (pass == 0) begin
        chk(host_mem[50] == 0, "R8 count cleared first", host_mem[50], 0);
        chk(host_mem[54] == 0, "R8 count cleared second", host_mem[54], 0);
      end else begin
        chk(host_mem[50] == 8, "R8 count kept", host_mem[50], 8);
        chk(host_mem[54] == 4, "R8 count kept second", host_mem[54], 4);
      end
      wreg(3'd5, 32'h8);
      @(negedge clk);
      chk(irq == 1'b0, "R9 irq cleared", {31'd0, irq}, 32'd0);
    end

    // R9 done interrupt
    wreg(3'd0, 32'h0); wreg(3'd1, 32'h0); wreg(3'd2, 32'd4);
    wreg(3'd3, 32'h0); wreg(3'd4, 32'h400);
    wreg(3'd5, 32'h3);
    wait_done("R9 run done");
    chk(irq == 1'b1, "R9 done irq", {31'd0, irq}, 32'd1);
    wreg(3'd5, 32'h8);

    // R10 abort
    stall = 1'b1;
    wreg(3'd0, 32'h0); wreg(3'd1, 32'h80); wreg(3'd2, 32'd64);
    wreg(3'd3, 32'h0); wreg(3'd4, 32'h0);
    w0 = wrs;
    wreg(3'd5, 32'h3);
    repeat (6) @(negedge clk);
    wreg(3'd5, 32'h5);
    wait_done("R10 abort done");
    n = wrs - w0;
    chk(n < 16, "R10 stopped early", n, 16);
    rreg(3'd2, d);
    chk(d == 64 - 4 * n, "R10 count kept", d, 64 - 4 * n);
    rreg(3'd0, d);
    chk(d == 4 * n, "R10 host address kept", d, 4 * n);
    a0 = acc;
    repeat (6) @(negedge clk);
    chk(acc == a0, "R10 quiet after abort", acc, a0);
    stall = 1'b0;

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule